// File: doc/BRIEF.md
# Status Condition-Code Generator

This block owns a 16-bit processor status word and keeps three of its fields current: the two-bit condition code, the carry flag and the overflow flag. On each update strobe it computes a fresh condition code from operands supplied by the datapath. The code can come from one of three evaluation rules, or it can be written directly. Carry and overflow are written at the same edge. Every other status field passes through untouched.

The arithmetic rule classifies a signed operand of up to 64 bits. The caller presents it as an upper word plus a lower word that is the OR of all the remaining words. The character rule classifies a single byte as a digit, a letter or anything else. The compare rule orders two operands of up to 32 bits, each given as an upper and a lower word. The upper words are compared as signed values and the lower words as unsigned values.

The stored code is also decoded into a disjoint one-hot flag triple. An instruction's flag mask is ANDed with this triple, and a non-zero result means the test passes, so "digit or letter" style tests need only a single AND. When overflow is written as 1 while the trap-enable status bit is set, the block raises a sticky integer-overflow interrupt flag. That flag stays up until it is acknowledged. Elsewhere in the chip, a full status word can be loaded into the register through a load port.

Top module: `ccgen_top`

## Requirements
- R1: After reset the status word is 0x0000 and the overflow interrupt flag is 0.
- R2: With mode 2'b00 (arithmetic), the code is set to 2'b10 (equal) when upper and lower are both zero. Otherwise it is set to 2'b01 (less) when bit 15 of the upper word is 1, and to 2'b00 (greater) when that bit is 0.
- R3: With mode 2'b01 (byte), the class is taken from bits [7:0] of operand A's lower word. Bytes 0x30..0x39 give 2'b00, bytes 0x41..0x5A and 0x61..0x7A give 2'b10, and every other byte gives 2'b01.
- R4: With mode 2'b10 (compare), equal upper words are decided by an unsigned comparison of the lower words. Unequal upper words are decided by a signed comparison of the upper words. A>B gives 2'b00, A<B gives 2'b01 and A=B gives 2'b10.
- R5: With mode 2'b11 (explicit), the code is set to the cc_in value, and this includes the invalid code 2'b11.
- R6: The code sits in status bits [9:8], carry in bit 10 and overflow in bit 11. An update writes these three fields one cycle after the strobe and leaves bits [15:12] and [7:0] unchanged. With no update and no load, the whole word holds.
- R7: An update with ovf_in=1 while status bit 13 (trap enable) is 1 sets ovf_irq at the next edge. The flag stays set until irq_ack is seen, and a set in the same cycle as irq_ack wins over the ack. With bit 13 at 0, overflow does not set the flag.
- R8: cc_onehot decodes the stored code as follows. Bit 0 is less (code 01), bit 1 is equal (code 10) and bit 2 is greater (code 00). The invalid code 11 decodes to 3'b011.
- R9: test_pass is 1 exactly when test_mask AND cc_onehot is non-zero.
- R10: st_load replaces the status word with st_load_data. When an update falls in the same cycle, bits [11:8] come from the update, all other bits come from st_load_data, and the trap-enable bit used for R7 is the loaded one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_load | input | 1 | Load whole status word |
| st_load_data | input | 16 | Status word to load |
| upd | input | 1 | Update strobe for code, carry and overflow |
| mode | input | 2 | 00 arithmetic, 01 byte, 10 compare, 11 explicit |
| opa_hi | input | 16 | Operand A upper word |
| opa_lo | input | 16 | Operand A lower word (byte in [7:0]) |
| opb_hi | input | 16 | Operand B upper word |
| opb_lo | input | 16 | Operand B lower word |
| cc_in | input | 2 | Explicit code value |
| carry_in | input | 1 | New carry flag |
| ovf_in | input | 1 | New overflow flag |
| irq_ack | input | 1 | Clears the overflow interrupt flag |
| test_mask | input | 3 | Instruction condition flag mask |
| status | output | 16 | Status word |
| ovf_irq | output | 1 | Integer-overflow interrupt flag |
| cc_onehot | output | 3 | One-hot decode of stored code |
| test_pass | output | 1 | Condition test result |

## Verification
A status load and an update can land in the same cycle. The update then merges onto the loaded word, and the trap-enable bit that gates the interrupt must come from the loaded word rather than from the old one. The bench drives st_load with a random trap-enable bit together with an update that raises overflow, in both directed and random cycles. It judges the merged word and the interrupt flag against a reference model that applies the load first and the update second. A set of the interrupt flag in the same cycle as an acknowledge is also provoked, and the flag is checked to remain set.

// File: rtl/ccgen_pkg.sv
package ccgen_pkg;
  typedef enum logic [1:0] {
    CC_GT  = 2'b00,
    CC_LT  = 2'b01,
    CC_EQ  = 2'b10,
    CC_BAD = 2'b11
  } cc_e;

  typedef enum logic [1:0] {
    MD_ARITH = 2'b00,
    MD_BYTE  = 2'b01,
    MD_CMP   = 2'b10,
    MD_EXPL  = 2'b11
  } mode_e;

  // status field positions, decoded by neighbouring logic
  localparam int CC_LSB  = 8;
  localparam int CC_MSB  = 9;
  localparam int CY_BIT  = 10;
  localparam int OV_BIT  = 11;
  localparam int TEN_BIT = 13;
  localparam int FLAGS_N = 3;
endpackage

// File: rtl/ccgen_classify.sv
module ccgen_classify
  import ccgen_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [1:0]   mode,
  input  logic [W-1:0] a_hi,
  input  logic [W-1:0] a_lo,
  input  logic [W-1:0] b_hi,
  input  logic [W-1:0] b_lo,
  input  logic [1:0]   cc_in,
  output logic [1:0]   cc_out
);
  localparam logic [W-1:0] SIGN = {1'b1, {(W-1){1'b0}}};

  logic [7:0] chr;
  logic       is_digit, is_upper, is_lower;
  logic [1:0] cc_arith, cc_byte, cc_cmp;

  assign chr      = a_lo[7:0];
  assign is_digit = (chr >= 8'h30) && (chr <= 8'h39);
  assign is_upper = (chr >= 8'h41) && (chr <= 8'h5A);
  assign is_lower = (chr >= 8'h61) && (chr <= 8'h7A);

  always_comb begin
    if ((a_hi | a_lo) == '0)   cc_arith = CC_EQ;
    else if (a_hi[W-1])        cc_arith = CC_LT;
    else                       cc_arith = CC_GT;
  end

  always_comb begin
    if (is_digit)                  cc_byte = CC_GT;
    else if (is_upper || is_lower) cc_byte = CC_EQ;
    else                           cc_byte = CC_LT;
  end

  always_comb begin
    if (a_hi == b_hi) begin
      if (a_lo == b_lo)      cc_cmp = CC_EQ;
      else if (a_lo < b_lo)  cc_cmp = CC_LT;
      else                   cc_cmp = CC_GT;
    end else if ((a_hi ^ SIGN) < (b_hi ^ SIGN)) begin
      cc_cmp = CC_LT;
    end else begin
      cc_cmp = CC_GT;
    end
  end

  always_comb begin
    unique case (mode)
      MD_ARITH: cc_out = cc_arith;
      MD_BYTE:  cc_out = cc_byte;
      MD_CMP:   cc_out = cc_cmp;
      default:  cc_out = cc_in;
    endcase
  end
endmodule

// File: rtl/ccgen_statreg.sv
module ccgen_statreg
  import ccgen_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_en,
  input  logic [W-1:0] ld_data,
  input  logic         upd,
  input  logic [1:0]   cc_new,
  input  logic         carry_in,
  input  logic         ovf_in,
  input  logic         ack,
  output logic [W-1:0] stat_q,
  output logic         irq_q
);
  logic [W-1:0] base, nxt;
  logic         irq_set;

  assign base = ld_en ? ld_data : stat_q;

  always_comb begin
    nxt = base;
    if (upd) begin
      nxt[CC_MSB:CC_LSB] = cc_new;
      nxt[CY_BIT]        = carry_in;
      nxt[OV_BIT]        = ovf_in;
    end
  end

  assign irq_set = upd & ovf_in & base[TEN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= nxt;
      irq_q  <= irq_set | (irq_q & ~ack);
    end
  end
endmodule

// File: rtl/ccgen_flagmap.sv
module ccgen_flagmap
  import ccgen_pkg::*;
(
  input  logic [1:0]         cc,
  input  logic [FLAGS_N-1:0] mask,
  output logic [FLAGS_N-1:0] onehot,
  output logic               pass
);
  // the greater code is all-zero, so it gets its own flag position
  assign onehot = (cc == CC_GT) ? 3'b100 : {1'b0, cc};
  assign pass   = |(mask & onehot);
endmodule

// File: rtl/ccgen_top.sv
module ccgen_top
  import ccgen_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         st_load,
  input  logic [W-1:0] st_load_data,
  input  logic         upd,
  input  logic [1:0]   mode,
  input  logic [W-1:0] opa_hi,
  input  logic [W-1:0] opa_lo,
  input  logic [W-1:0] opb_hi,
  input  logic [W-1:0] opb_lo,
  input  logic [1:0]   cc_in,
  input  logic         carry_in,
  input  logic         ovf_in,
  input  logic         irq_ack,
  input  logic [2:0]   test_mask,
  output logic [W-1:0] status,
  output logic         ovf_irq,
  output logic [2:0]   cc_onehot,
  output logic         test_pass
);
  logic [1:0] cc_calc;

  ccgen_classify #(.W(W)) u_cls (
    .mode(mode), .a_hi(opa_hi), .a_lo(opa_lo),
    .b_hi(opb_hi), .b_lo(opb_lo), .cc_in(cc_in), .cc_out(cc_calc)
  );

  ccgen_statreg #(.W(W)) u_reg (
    .clk(clk), .rst(rst), .ld_en(st_load), .ld_data(st_load_data),
    .upd(upd), .cc_new(cc_calc), .carry_in(carry_in), .ovf_in(ovf_in),
    .ack(irq_ack), .stat_q(status), .irq_q(ovf_irq)
  );

  ccgen_flagmap u_map (
    .cc(status[CC_MSB:CC_LSB]), .mask(test_mask),
    .onehot(cc_onehot), .pass(test_pass)
  );
endmodule

// File: rtl/ccgen_chk.sv
module ccgen_chk
  import ccgen_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         st_load,
  input logic [W-1:0] st_load_data,
  input logic         upd,
  input logic [1:0]   mode,
  input logic [1:0]   cc_in,
  input logic         carry_in,
  input logic         ovf_in,
  input logic         irq_ack,
  input logic [2:0]   test_mask,
  input logic [W-1:0] status,
  input logic         ovf_irq,
  input logic [2:0]   cc_onehot,
  input logic         test_pass
);
  logic ten_eff;
  assign ten_eff = st_load ? st_load_data[TEN_BIT] : status[TEN_BIT];

  // R6
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!upd && !st_load) |=> $stable(status));

  // R6
  p_keep_fields_r6: assert property (@(posedge clk) disable iff (rst)
    (upd && !st_load) |=> (status[W-1:12] == $past(status[W-1:12]))
                          && (status[7:0] == $past(status[7:0])));

  // R6
  p_flags_r6: assert property (@(posedge clk) disable iff (rst)
    upd |=> (status[CY_BIT] == $past(carry_in)) && (status[OV_BIT] == $past(ovf_in)));

  // R5
  p_explicit_r5: assert property (@(posedge clk) disable iff (rst)
    (upd && mode == MD_EXPL) |=> status[CC_MSB:CC_LSB] == $past(cc_in));

  // R7
  p_irq_set_r7: assert property (@(posedge clk) disable iff (rst)
    (upd && ovf_in && ten_eff) |=> ovf_irq);

  // R7
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf_irq && !irq_ack) |=> ovf_irq);

  // R7
  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!ovf_irq && !(upd && ovf_in && ten_eff)) |=> !ovf_irq);

  // R8
  p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    (status[CC_MSB:CC_LSB] != CC_BAD) |-> ($countones(cc_onehot) == 1));

  // R9
  p_nomask_r9: assert property (@(posedge clk) disable iff (rst)
    (test_mask == 3'b000) |-> !test_pass);
endmodule

bind ccgen_top ccgen_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .st_load(st_load), .st_load_data(st_load_data),
  .upd(upd), .mode(mode), .cc_in(cc_in), .carry_in(carry_in),
  .ovf_in(ovf_in), .irq_ack(irq_ack), .test_mask(test_mask),
  .status(status), .ovf_irq(ovf_irq), .cc_onehot(cc_onehot),
  .test_pass(test_pass)
);

// File: tb/sim_ccgen_top.sv
`timescale 1ns/1ps
module sim_ccgen_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        st_load;
  logic [15:0] st_load_data;
  logic        upd;
  logic [1:0]  mode;
  logic [15:0] opa_hi, opa_lo, opb_hi, opb_lo;
  logic [1:0]  cc_in;
  logic        carry_in, ovf_in, irq_ack;
  logic [2:0]  test_mask;
  logic [15:0] status;
  logic        ovf_irq;
  logic [2:0]  cc_onehot;
  logic        test_pass;

  int checks = 0;
  int fails  = 0;
  logic [15:0] m_stat;
  logic        m_irq;

  always #2.5 clk = ~clk;

  ccgen_top u0 (
    .clk(clk), .rst(rst), .st_load(st_load), .st_load_data(st_load_data),
    .upd(upd), .mode(mode), .opa_hi(opa_hi), .opa_lo(opa_lo),
    .opb_hi(opb_hi), .opb_lo(opb_lo), .cc_in(cc_in), .carry_in(carry_in),
    .ovf_in(ovf_in), .irq_ack(irq_ack), .test_mask(test_mask),
    .status(status), .ovf_irq(ovf_irq), .cc_onehot(cc_onehot),
    .test_pass(test_pass)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] f_arith(input logic [15:0] h, input logic [15:0] l);
    if (h == 0 && l == 0) return 2'b10;
    return h[15] ? 2'b01 : 2'b00;
  endfunction

  function automatic logic [1:0] f_byte(input logic [7:0] b);
    if (b >= 8'd48 && b <= 8'd57) return 2'b00;
    if ((b >= 8'd65 && b <= 8'd90) || (b >= 8'd97 && b <= 8'd122)) return 2'b10;
    return 2'b01;
  endfunction

  function automatic logic [1:0] f_cmp(input logic [15:0] ah, al, bh, bl);
    logic signed [31:0] sa, sb;
    if (ah == bh) begin
      if (al == bl) return 2'b10;
      return (al < bl) ? 2'b01 : 2'b00;
    end
    sa = {{16{ah[15]}}, ah};
    sb = {{16{bh[15]}}, bh};
    return (sa < sb) ? 2'b01 : 2'b00;
  endfunction

  function automatic logic [2:0] f_hot(input logic [1:0] c);
    case (c)
      2'b00:   return 3'b100;
      2'b01:   return 3'b001;
      2'b10:   return 3'b010;
      default: return 3'b011;
    endcase
  endfunction

  // drives one cycle right after a falling edge, checks at the next falling edge
  task automatic cyc(input logic ld, input logic [15:0] ldd, input logic u,
                     input logic [1:0] m, input logic [15:0] ah, al, bh, bl,
                     input logic [1:0] ci, input logic cy, input logic ov,
                     input logic ak, input logic [2:0] msk);
    logic [15:0] base;
    logic [1:0]  c;
    string       tag;
    st_load = ld; st_load_data = ldd; upd = u; mode = m;
    opa_hi = ah; opa_lo = al; opb_hi = bh; opb_lo = bl;
    cc_in = ci; carry_in = cy; ovf_in = ov; irq_ack = ak; test_mask = msk;
    base = ld ? ldd : m_stat;
    case (m)
      2'b00:   c = f_arith(ah, al);
      2'b01:   c = f_byte(al[7:0]);
      2'b10:   c = f_cmp(ah, al, bh, bl);
      default: c = ci;
    endcase
    m_irq = (u && ov && base[13]) || (m_irq && !ak);
    if (u) begin
      base[9:8] = c; base[10] = cy; base[11] = ov;
    end
    m_stat = base;
    if (ld)            tag = "R10 load/merge";
    else if (!u)       tag = "R6 hold";
    else if (m == 0)   tag = "R2 arith";
    else if (m == 1)   tag = "R3 byte";
    else if (m == 2)   tag = "R4 compare";
    else               tag = "R5 explicit";
    @(negedge clk);
    chk(tag, {16'h0, status}, {16'h0, m_stat});
    chk("R7 ovf_irq", {31'h0, ovf_irq}, {31'h0, m_irq});
    chk("R8 onehot", {29'h0, cc_onehot}, {29'h0, f_hot(m_stat[9:8])});
    chk("R9 test_pass", {31'h0, test_pass}, {31'h0, |(msk & f_hot(m_stat[9:8]))});
  endtask

  function automatic logic [15:0] pick();
    case ($urandom % 5)
      0: return 16'h0000;
      1: return 16'h8000;
      2: return 16'h7FFF;
      3: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; st_load = 0; st_load_data = 0; upd = 0; mode = 0;
    opa_hi = 0; opa_lo = 0; opb_hi = 0; opb_lo = 0; cc_in = 0;
    carry_in = 0; ovf_in = 0; irq_ack = 0; test_mask = 0;
    m_stat = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 reset status", {16'h0, status}, 32'h0);
    chk("R1 reset irq", {31'h0, ovf_irq}, 32'h0);

    // R2 arithmetic corners
    cyc(0, 0, 1, 2'b00, 16'h0000, 16'h0000, 0, 0, 0, 0, 0, 0, 3'b010);
    cyc(0, 0, 1, 2'b00, 16'h0000, 16'h0001, 0, 0, 0, 1, 0, 0, 3'b100);
    cyc(0, 0, 1, 2'b00, 16'h8000, 16'h0000, 0, 0, 0, 0, 0, 0, 3'b001);
    // R3 byte corners
    cyc(0, 0, 1, 2'b01, 0, 16'h0030, 0, 0, 0, 0, 0, 0, 3'b100);
    cyc(0, 0, 1, 2'b01, 0, 16'h0039, 0, 0, 0, 0, 0, 0, 3'b110);
    cyc(0, 0, 1, 2'b01, 0, 16'h005A, 0, 0, 0, 0, 0, 0, 3'b110);
    cyc(0, 0, 1, 2'b01, 0, 16'h0040, 0, 0, 0, 0, 0, 0, 3'b110);
    cyc(0, 0, 1, 2'b01, 0, 16'h007B, 0, 0, 0, 0, 0, 0, 3'b001);
    // R4 compare corners
    cyc(0, 0, 1, 2'b10, 16'h0005, 16'hFFFF, 16'h0005, 16'h0001, 0, 0, 0, 0, 3'b100);
    cyc(0, 0, 1, 2'b10, 16'hFFFF, 16'h0000, 16'h0001, 16'h0000, 0, 0, 0, 0, 3'b001);
    cyc(0, 0, 1, 2'b10, 16'h1234, 16'h5678, 16'h1234, 16'h5678, 0, 0, 0, 0, 3'b010);
    // R5 explicit invalid code
    cyc(0, 0, 1, 2'b11, 0, 0, 0, 0, 2'b11, 1, 0, 0, 3'b011);
    // R6 hold with no strobe
    cyc(0, 0, 0, 2'b00, 16'h1111, 0, 0, 0, 0, 0, 0, 0, 3'b111);
    // R7 overflow without trap enable: no interrupt
    cyc(0, 0, 1, 2'b11, 0, 0, 0, 0, 2'b00, 0, 1, 0, 3'b100);
    // R10 load with trap enable plus overflow update in same cycle
    cyc(1, 16'hA0F3, 1, 2'b00, 16'h8000, 0, 0, 0, 0, 1, 1, 0, 3'b001);
    // R7 set coinciding with ack: set wins
    cyc(0, 0, 1, 2'b00, 0, 0, 0, 0, 0, 0, 1, 1, 3'b010);
    // R7 ack clears
    cyc(0, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0, 1, 3'b000);
    // R10 load alone
    cyc(1, 16'h5A5A, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 3'b111);

    for (int i = 0; i < 600; i++) begin
      logic [15:0] ah, bh, al, bl;
      ah = pick(); al = pick();
      bh = ($urandom % 3 == 0) ? ah : pick();
      bl = ($urandom % 3 == 0) ? al : pick();
      cyc(($urandom % 8) == 0, 16'($urandom), ($urandom % 4) != 0,
          2'($urandom), ah, al, bh, bl, 2'($urandom), 1'($urandom),
          1'($urandom), ($urandom % 4) == 0, 3'($urandom));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule